// File: doc/BRIEF.md
# Parallel Port FIFO Service Controller

This block sits next to the data FIFO of an extended-capability parallel port. It decides when the port asks the host for service. Two service methods are supported. With DMA enabled, it raises a DMA request for as long as the FIFO can move data in the selected direction. With DMA disabled, it raises a programmed-I/O interrupt once the occupancy, or the free space, reaches a programmable threshold.

The block owns the service-interrupt control bit. Software writes that bit through a write strobe. A terminal-count cycle from the host DMA controller sets the bit to 1. A set bit blocks all DMA requests until software clears it again. A FIFO that runs empty, or full when writing, only pauses requests; they resume by themselves.

Bursts of back-to-back DMA cycles are capped, so that other bus users such as memory refresh are not starved.

Top module: `pfifo_svc`

## Requirements
- R1: After reset, `dmaReq`, `intrOut` and `svcIntr` are all 0.
- R2: When `dirToHost`=1, `dmaEn`=1 and `svcIntr`=0, `dmaReq` is 1 in the cycle after `fifoLevel` is at least 1.
- R3: When `dirToHost`=1 and `fifoLevel`=0, `dmaReq` is 0 in the next cycle. It returns to 1 one cycle after a byte is present again, with no write to `svcIntr`.
- R4: A `tcStrobe` pulse while `dmaEn`=1 makes `svcIntr`=1 and `intrOut`=1 and `dmaReq`=0 in the next cycle. This holds even if a software write to `svcIntr` happens in the same cycle.
- R5: After a terminal count, `dmaReq` stays 0 until software writes `svcIntr` to 0 (`swSvcWr`=1, `swSvcData`=0). That write also clears the terminal-count interrupt. The request then returns one cycle later if the FIFO can move data.
- R6: At most 32 `dmaAck` cycles are accepted in a row while `dmaReq` is 1. After the 32nd, `dmaReq` is 0 for exactly one cycle and then may assert again. The run count restarts whenever `dmaReq` is 0.
- R7: If `svcIntr` is 1 or `dmaEn` is 0 in a cycle, `dmaReq` is 0 in the next cycle.
- R8: In programmed-I/O mode (`dmaEn`=0, `svcIntr`=0) with `dirToHost`=1, `intrOut` is 1 in the next cycle exactly when `fifoLevel` >= `thrField`+1.
- R9: In programmed-I/O mode with `dirToHost`=0, `intrOut` is 1 in the next cycle exactly when the free space (16 − `fifoLevel`) >= `thrField`+1.
- R10: When `dirToHost`=0, `dmaEn`=1 and `svcIntr`=0, `dmaReq` is 1 in the next cycle exactly when `fifoLevel` < 16 (the FIFO is not full).
- R11: A `tcStrobe` pulse while `dmaEn`=0 is ignored. `svcIntr` keeps its value and `intrOut` follows only the programmed-I/O rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirToHost | input | 1 | 1: FIFO drains toward the host; 0: host fills the FIFO |
| fifoLevel | input | 5 | Current FIFO occupancy, 0 to 16 |
| thrField | input | 4 | Service threshold minus one |
| dmaEn | input | 1 | DMA service enable |
| swSvcWr | input | 1 | Software write strobe for the service-interrupt bit |
| swSvcData | input | 1 | Value written to the service-interrupt bit |
| dmaAck | input | 1 | One pulse per DMA cycle performed by the host |
| tcStrobe | input | 1 | Terminal-count cycle received |
| dmaReq | output | 1 | DMA request toward the host |
| intrOut | output | 1 | Service interrupt (programmed-I/O level or terminal count) |
| svcIntr | output | 1 | Current service-interrupt bit |

## Verification
The hardest situation to reach is the burst cap. It needs 32 acknowledged cycles in an unbroken run. Any empty FIFO, terminal count or software write in between drops the request and restarts the count.

A directed sequence holds the FIFO non-empty and acknowledges every cycle. It checks the request just before, at and after the forced gap. The random phase uses a strongly biased acknowledge and rare terminal counts, so that long runs also arise mixed with the other events.

// File: rtl/pfifo_svc_pkg.sv
package pfifo_svc_pkg;
  // strobes from the control section to the datapath
  typedef struct packed {
    logic burstInc;   // one more acknowledged cycle in the current run
    logic burstClr;   // run has ended, restart the count
  } svcStrobe_t;
endpackage

// File: rtl/pfifo_svc_dp.sv
module pfifo_svc_dp
  import pfifo_svc_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BURST_MAX = 32,
  parameter int LVL_W     = $clog2(DEPTH + 1),
  parameter int THR_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirToHost,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0] thrField,
  input  svcStrobe_t       strobes,
  output logic             hasRoom,
  output logic             thrMet,
  output logic             burstLast
);
  localparam int BW = $clog2(BURST_MAX);
  localparam logic [BW-1:0] LAST_CNT = BW'(BURST_MAX - 1);

  logic [LVL_W-1:0] thrCount;
  logic [LVL_W-1:0] freeSlots;
  logic [BW-1:0]    burstCnt;

  assign thrCount  = LVL_W'(thrField) + LVL_W'(1);
  assign freeSlots = LVL_W'(DEPTH) - fifoLevel;

  // movable data: bytes to drain, or slots to fill
  assign hasRoom = dirToHost ? (fifoLevel != '0) : (fifoLevel != LVL_W'(DEPTH));
  assign thrMet  = dirToHost ? (fifoLevel >= thrCount) : (freeSlots >= thrCount);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.burstClr) burstCnt <= '0;
    else if (strobes.burstInc)     burstCnt <= burstCnt + BW'(1);
  end

  assign burstLast = (burstCnt == LAST_CNT);
endmodule

// File: rtl/pfifo_svc_ctl.sv
module pfifo_svc_ctl
  import pfifo_svc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaEn,
  input  logic       swSvcWr,
  input  logic       swSvcData,
  input  logic       dmaAck,
  input  logic       tcStrobe,
  input  logic       hasRoom,
  input  logic       thrMet,
  input  logic       burstLast,
  output svcStrobe_t strobes,
  output logic       dmaReq,
  output logic       intrOut,
  output logic       svcIntr
);
  logic reqQ, svcQ, tcFlagQ, pioQ;
  logic tcHit, capHit;

  assign tcHit  = tcStrobe && dmaEn;
  assign capHit = reqQ && dmaAck && burstLast;

  assign strobes.burstInc = reqQ && dmaAck;
  assign strobes.burstClr = !reqQ || capHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      svcQ    <= 1'b0;
      tcFlagQ <= 1'b0;
      pioQ    <= 1'b0;
    end else begin
      reqQ <= dmaEn && !svcQ && !tcHit && hasRoom && !capHit;
      pioQ <= !dmaEn && !svcQ && thrMet;
      if (tcHit) begin
        svcQ    <= 1'b1;
        tcFlagQ <= 1'b1;
      end else if (swSvcWr) begin
        svcQ <= swSvcData;
        if (!swSvcData) tcFlagQ <= 1'b0;
      end
    end
  end

  assign dmaReq  = reqQ;
  assign intrOut = pioQ || tcFlagQ;
  assign svcIntr = svcQ;
endmodule

// File: rtl/pfifo_svc.sv
module pfifo_svc
  import pfifo_svc_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BURST_MAX = 32,
  parameter int LVL_W     = $clog2(DEPTH + 1),
  parameter int THR_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirToHost,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0] thrField,
  input  logic             dmaEn,
  input  logic             swSvcWr,
  input  logic             swSvcData,
  input  logic             dmaAck,
  input  logic             tcStrobe,
  output logic             dmaReq,
  output logic             intrOut,
  output logic             svcIntr
);
  svcStrobe_t strobes;
  logic hasRoom, thrMet, burstLast;

  pfifo_svc_dp #(.DEPTH(DEPTH), .BURST_MAX(BURST_MAX), .LVL_W(LVL_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .dirToHost(dirToHost), .fifoLevel(fifoLevel),
    .thrField(thrField), .strobes(strobes), .hasRoom(hasRoom),
    .thrMet(thrMet), .burstLast(burstLast)
  );

  pfifo_svc_ctl u_ctl (
    .clk(clk), .rstN(rstN), .dmaEn(dmaEn), .swSvcWr(swSvcWr),
    .swSvcData(swSvcData), .dmaAck(dmaAck), .tcStrobe(tcStrobe),
    .hasRoom(hasRoom), .thrMet(thrMet), .burstLast(burstLast),
    .strobes(strobes), .dmaReq(dmaReq), .intrOut(intrOut), .svcIntr(svcIntr)
  );
endmodule

// File: rtl/pfifo_svc_chk.sv
module pfifo_svc_chk #(
  parameter int DEPTH     = 16,
  parameter int BURST_MAX = 32,
  parameter int LVL_W     = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             dirToHost,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             dmaEn,
  input logic             swSvcWr,
  input logic             dmaAck,
  input logic             tcStrobe,
  input logic             dmaReq,
  input logic             intrOut,
  input logic             svcIntr
);
  int unsigned ackRun;

  always_ff @(posedge clk) begin
    if (!rstN || !dmaReq) ackRun <= 0;
    else if (dmaAck)      ackRun <= ackRun + 1;
  end

  // R4
  tc_sets_svc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tcStrobe && dmaEn) |=> (svcIntr && intrOut && !dmaReq));

  // R7
  svc_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcIntr || !dmaEn) |=> !dmaReq);

  // R3
  empty_stops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirToHost && fifoLevel == '0) |=> !dmaReq);

  // R10
  full_stops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dirToHost && fifoLevel == LVL_W'(DEPTH)) |=> !dmaReq);

  // R11
  tc_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tcStrobe && !dmaEn && !swSvcWr) |=> $stable(svcIntr));

  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackRun <= BURST_MAX);
endmodule

bind pfifo_svc pfifo_svc_chk #(.DEPTH(DEPTH), .BURST_MAX(BURST_MAX), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .dirToHost(dirToHost), .fifoLevel(fifoLevel),
  .dmaEn(dmaEn), .swSvcWr(swSvcWr), .dmaAck(dmaAck), .tcStrobe(tcStrobe),
  .dmaReq(dmaReq), .intrOut(intrOut), .svcIntr(svcIntr)
);

// File: tb/pfifo_svc_tb.sv
`timescale 1ns/1ps
module pfifo_svc_tb;
  localparam int DEPTH = 16;
  localparam int BMAX  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirToHost = 1'b1;
  logic [4:0] fifoLevel = '0;
  logic [3:0] thrField = '0;
  logic dmaEn = 1'b0, swSvcWr = 1'b0, swSvcData = 1'b0, dmaAck = 1'b0, tcStrobe = 1'b0;
  logic dmaReq, intrOut, svcIntr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic mReq, mSvc, mTc, mPio;
  int   mCnt;

  always #4 clk = ~clk;

  pfifo_svc u_dut (
    .clk(clk), .rstN(rstN), .dirToHost(dirToHost), .fifoLevel(fifoLevel),
    .thrField(thrField), .dmaEn(dmaEn), .swSvcWr(swSvcWr), .swSvcData(swSvcData),
    .dmaAck(dmaAck), .tcStrobe(tcStrobe), .dmaReq(dmaReq), .intrOut(intrOut),
    .svcIntr(svcIntr)
  );

  function automatic bit roomOk(input logic toHost, input int lvl);
    return toHost ? (lvl != 0) : (lvl != DEPTH);
  endfunction

  function automatic bit thrOk(input logic toHost, input int lvl, input int thr);
    return toHost ? (lvl >= thr + 1) : ((DEPTH - lvl) >= thr + 1);
  endfunction

  task automatic modelReset();
    mReq = 0; mSvc = 0; mTc = 0; mPio = 0; mCnt = 0;
  endtask

  task automatic modelEdge();
    logic tcHit, capHit;
    tcHit  = tcStrobe && dmaEn;
    capHit = mReq && dmaAck && (mCnt == BMAX - 1);
    mPio = !dmaEn && !mSvc && thrOk(dirToHost, int'(fifoLevel), int'(thrField));
    if (!mReq || capHit) mCnt = 0;
    else if (dmaAck) mCnt = mCnt + 1;
    mReq = dmaEn && !mSvc && !tcHit && roomOk(dirToHost, int'(fifoLevel)) && !capHit;
    if (tcHit) begin
      mSvc = 1; mTc = 1;
    end else if (swSvcWr) begin
      mSvc = swSvcData;
      if (!swSvcData) mTc = 0;
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: reference and design advance together, compare at negedge
  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check("model dmaReq",  dmaReq,  mReq);
    check("model intrOut", intrOut, mPio | mTc);
    check("model svcIntr", svcIntr, mSvc);
    swSvcWr = 0; tcStrobe = 0;
  endtask

  task automatic swWrite(input logic v);
    swSvcWr = 1; swSvcData = v;
    step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    check("R1 dmaReq",  dmaReq,  1'b0);
    check("R1 intrOut", intrOut, 1'b0);
    check("R1 svcIntr", svcIntr, 1'b0);

    // R2: drain toward host
    dirToHost = 1; dmaEn = 1; fifoLevel = 3;
    step(); check("R2 req with data", dmaReq, 1'b1);

    // R3: empty pauses, auto re-arm
    fifoLevel = 0; step(); check("R3 req empty", dmaReq, 1'b0);
    fifoLevel = 1; step(); check("R3 req rearm", dmaReq, 1'b1);

    // R6: burst cap
    fifoLevel = 5; dmaAck = 1;
    for (int i = 0; i < BMAX - 1; i++) step();
    check("R6 req before cap", dmaReq, 1'b1);
    step(); check("R6 gap after cap", dmaReq, 1'b0);
    step(); check("R6 req after gap", dmaReq, 1'b1);
    dmaAck = 0;

    // R4: terminal count, concurrent software write loses
    tcStrobe = 1; swSvcWr = 1; swSvcData = 0;
    step();
    check("R4 svcIntr", svcIntr, 1'b1);
    check("R4 intrOut", intrOut, 1'b1);
    check("R4 dmaReq",  dmaReq,  1'b0);

    // R5: stays off until cleared
    step(); step(); check("R5 still off", dmaReq, 1'b0);
    swWrite(0);
    check("R5 svc cleared", svcIntr, 1'b0);
    check("R5 tc intr cleared", intrOut, 1'b0);
    step(); check("R5 req resumes", dmaReq, 1'b1);

    // R7: abort sequence
    swWrite(1); step(); check("R7 req off by svc", dmaReq, 1'b0);
    dmaEn = 0; swWrite(0); step(); check("R7 req off by dmaEn", dmaReq, 1'b0);

    // R11: terminal count in programmed-I/O mode
    thrField = 5; fifoLevel = 2; step();
    tcStrobe = 1; step();
    check("R11 svc kept", svcIntr, 1'b0);
    check("R11 no intr", intrOut, 1'b0);

    // R8: read-direction threshold
    fifoLevel = 5; step(); check("R8 below thr", intrOut, 1'b0);
    fifoLevel = 6; step(); check("R8 at thr", intrOut, 1'b1);
    thrField = 15; fifoLevel = 15; step(); check("R8 15 of 16", intrOut, 1'b0);
    fifoLevel = 16; step(); check("R8 16 of 16", intrOut, 1'b1);
    thrField = 0; fifoLevel = 0; step(); check("R8 empty thr1", intrOut, 1'b0);
    fifoLevel = 1; step(); check("R8 one thr1", intrOut, 1'b1);

    // R9: write-direction threshold
    dirToHost = 0; thrField = 3; fifoLevel = 12; step(); check("R9 free 4", intrOut, 1'b1);
    fifoLevel = 13; step(); check("R9 free 3", intrOut, 1'b0);

    // R10: fill from host
    dmaEn = 1; fifoLevel = 16; step(); check("R10 full", dmaReq, 1'b0);
    fifoLevel = 15; step(); check("R10 not full", dmaReq, 1'b1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      dirToHost = ($urandom % 8) != 0 ? dirToHost : ~dirToHost;
      fifoLevel = 5'($urandom % (DEPTH + 1));
      if (($urandom % 4) != 0) fifoLevel = (dirToHost ? 5'd8 : 5'd4);
      thrField  = 4'($urandom);
      if (($urandom % 40) == 0) dmaEn = ~dmaEn;
      dmaAck    = ($urandom % 16) != 0;
      tcStrobe  = ($urandom % 90) == 0;
      swSvcWr   = ($urandom % 50) == 0;
      swSvcData = ($urandom % 3) == 0;
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule